// File: doc/BRIEF.md
# Interrupt Request Recognition Logic

This block decides, once per instruction boundary, whether the processor should enter an interrupt acknowledge sequence, and with which vector type number. Two request paths feed it. The first is a maskable, active-high level request that is gated by the software interrupt-enable flag. The second is a non-maskable path built from a memory parity error qualified by its own enable, ORed with one or more auxiliary sources.

The instruction sequencer raises an end-of-instruction strobe during the last clock of every instruction. The maskable level is looked at only in that clock. A rising edge on the non-maskable path is caught in any clock and held in a pending flag until a boundary services it.

When a boundary grants a request, the block emits a one-cycle start pulse together with the type number. The type is fixed at 2 for the non-maskable path. For the maskable path it is taken from an input byte that stands in for the value the acknowledge bus cycle would fetch. Vector fetches, flag stacking and the bus cycles themselves belong to neighbouring logic.

Top module: `intr_recog`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ack_start`, `nmi_pending` and `ack_type` are all 0.
- R2: `maskable_req` is sampled only at a clock edge where `instr_end` is 1. A request that is present only while `instr_end` is 0 never produces `ack_start`.
- R3: At a boundary edge with no NMI pending, `maskable_req`=1 and `int_enable`=1 make `ack_start` 1 in the following cycle, with `ack_type` equal to `ext_type` as sampled at that edge. With `int_enable`=0 the request has no effect on `ack_start` or `ack_type`.
- R4: The non-maskable source is `(parity_err & nmi_en) | (OR of all aux_nmi bits)`. A 0-to-1 change of the source seen at one clock edge sets `nmi_pending` in the next cycle. A source held at 1 does not set it again.
- R5: The non-maskable path ignores `int_enable`. A boundary edge with `nmi_pending`=1 gives `ack_start`=1 and `ack_type`=2 in the next cycle, and `nmi_pending` drops in that same cycle.
- R6: `nmi_pending` stays set until a boundary services it. Two or more edges before that boundary yield exactly one non-maskable acknowledge.
- R7: When an NMI is pending and an enabled maskable request is present at the same boundary, the NMI is served. The maskable request is then taken at a later boundary if it is still present.
- R8: A source already at 1 when reset is released is not treated as an edge. The first clock edge after reset only samples the source.
- R9: An edge that arrives in the same cycle as the boundary that services a pending NMI sets `nmi_pending` again. It is served at the next boundary.
- R10: `ack_type` keeps its value in every cycle in which `ack_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| maskable_req | input | 1 | Level-sensitive maskable request, active high |
| int_enable | input | 1 | Software interrupt-enable flag |
| parity_err | input | 1 | Memory parity error |
| nmi_en | input | 1 | Enable for the parity error on the non-maskable path |
| aux_nmi | input | AUX_W | Auxiliary non-maskable sources, ORed together |
| instr_end | input | 1 | High in the last clock of each instruction |
| ext_type | input | TYPE_W | Type number supplied for a maskable acknowledge |
| ack_start | output | 1 | One-cycle pulse that starts an acknowledge |
| ack_type | output | TYPE_W | Type number of the acknowledge |
| nmi_pending | output | 1 | Latched non-maskable request awaiting service |

## Verification
The hardest case to reach is an edge on the non-maskable source that lands in the very clock in which a boundary clears the pending flag. Reaching it needs an earlier edge already latched, the source dropped again, and then `instr_end` and the source raised together in one drive cycle. The bench builds this sequence by hand. It also sweeps every combination of parity error, enable and auxiliary source, and every combination of request and enable flag across several type bytes. A reference model, updated from the requirements each cycle, compares all outputs after every clock.

// File: rtl/intr_recog_pkg.sv
package intr_recog_pkg;

    // Which source a boundary grants
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_NMI  = 2'd1,
        SEL_MASK = 2'd2
    } svc_sel_e;

    // State of the non-maskable edge catcher
    typedef struct packed {
        logic primed;    // source sampled at least once since reset
        logic src_seen;  // source level at the previous edge
        logic pending;   // latched request awaiting service
    } edge_state_t;

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch
    import intr_recog_pkg::*;
#(
    parameter int unsigned AUX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             parity_err,
    input  logic             nmi_en,
    input  logic [AUX_W-1:0] aux_src,
    input  logic             take,
    output logic             pending
);

    edge_state_t st_d;
    edge_state_t st_q;
    logic        src_lvl;
    logic        rise;

    always_comb begin
        src_lvl     = (parity_err & nmi_en) | (|aux_src);
        rise        = st_q.primed & src_lvl & ~st_q.src_seen;
        st_d        = st_q;
        st_d.primed = 1'b1;
        st_d.src_seen = src_lvl;
        // a new edge wins over a clear in the same cycle
        st_d.pending  = rise | (st_q.pending & ~take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pending;

endmodule

// File: rtl/boundary_arbiter.sv
module boundary_arbiter
    import intr_recog_pkg::*;
#(
    parameter int unsigned TYPE_W   = 8,
    parameter int unsigned NMI_TYPE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_end,
    input  logic              nmi_pending,
    input  logic              mask_req,
    input  logic              int_en,
    input  logic [TYPE_W-1:0] ext_type,
    output logic              take_nmi,
    output logic              ack_start,
    output logic [TYPE_W-1:0] ack_type
);

    localparam logic [TYPE_W-1:0] NmiVec = TYPE_W'(NMI_TYPE);

    typedef struct packed {
        logic              ack;
        logic [TYPE_W-1:0] vtype;
    } arb_state_t;

    arb_state_t st_d;
    arb_state_t st_q;
    svc_sel_e   sel;

    always_comb begin
        sel = SEL_NONE;
        if (instr_end) begin
            if (nmi_pending) begin
                sel = SEL_NMI;
            end else if (mask_req && int_en) begin
                sel = SEL_MASK;
            end
        end

        st_d     = st_q;
        st_d.ack = (sel != SEL_NONE);
        case (sel)
            SEL_NMI:  st_d.vtype = NmiVec;
            SEL_MASK: st_d.vtype = ext_type;
            default:  st_d.vtype = st_q.vtype;
        endcase
        take_nmi = (sel == SEL_NMI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_start = st_q.ack;
    assign ack_type  = st_q.vtype;

endmodule

// File: rtl/intr_recog.sv
module intr_recog #(
    parameter int unsigned TYPE_W   = 8,
    parameter int unsigned AUX_W    = 1,
    parameter int unsigned NMI_TYPE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              maskable_req,
    input  logic              int_enable,
    input  logic              parity_err,
    input  logic              nmi_en,
    input  logic [AUX_W-1:0]  aux_nmi,
    input  logic              instr_end,
    input  logic [TYPE_W-1:0] ext_type,
    output logic              ack_start,
    output logic [TYPE_W-1:0] ack_type,
    output logic              nmi_pending
);

    logic take_nmi;

    nmi_edge_latch #(
        .AUX_W (AUX_W)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .parity_err (parity_err),
        .nmi_en     (nmi_en),
        .aux_src    (aux_nmi),
        .take       (take_nmi),
        .pending    (nmi_pending)
    );

    boundary_arbiter #(
        .TYPE_W   (TYPE_W),
        .NMI_TYPE (NMI_TYPE)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_end   (instr_end),
        .nmi_pending (nmi_pending),
        .mask_req    (maskable_req),
        .int_en      (int_enable),
        .ext_type    (ext_type),
        .take_nmi    (take_nmi),
        .ack_start   (ack_start),
        .ack_type    (ack_type)
    );

endmodule

// File: rtl/intr_recog_chk.sv
module intr_recog_chk #(
    parameter int unsigned TYPE_W   = 8,
    parameter int unsigned AUX_W    = 1,
    parameter int unsigned NMI_TYPE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              maskable_req,
    input logic              int_enable,
    input logic              parity_err,
    input logic              nmi_en,
    input logic [AUX_W-1:0]  aux_nmi,
    input logic              instr_end,
    input logic [TYPE_W-1:0] ext_type,
    input logic              ack_start,
    input logic [TYPE_W-1:0] ack_type,
    input logic              nmi_pending
);

    logic src_now;
    assign src_now = (parity_err & nmi_en) | (|aux_nmi);

    AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ack_start |-> $past(instr_end)); // R2

    AST_MASK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_start && !$past(nmi_pending)) |->
            ($past(int_enable && maskable_req) && ack_type == $past(ext_type))); // R3

    AST_PEND_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pending) |-> $past(src_now)); // R4

    AST_NMI_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end && nmi_pending) |=> (ack_start && ack_type == TYPE_W'(NMI_TYPE))); // R5

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pending && !instr_end) |=> nmi_pending); // R6

    AST_TYPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_start |-> $stable(ack_type)); // R10

endmodule

bind intr_recog intr_recog_chk #(
    .TYPE_W   (TYPE_W),
    .AUX_W    (AUX_W),
    .NMI_TYPE (NMI_TYPE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .maskable_req (maskable_req),
    .int_enable   (int_enable),
    .parity_err   (parity_err),
    .nmi_en       (nmi_en),
    .aux_nmi      (aux_nmi),
    .instr_end    (instr_end),
    .ext_type     (ext_type),
    .ack_start    (ack_start),
    .ack_type     (ack_type),
    .nmi_pending  (nmi_pending)
);

// File: tb/intr_recog_bench.sv
module intr_recog_bench;

    localparam int TW = 8;
    localparam int AW = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          maskable_req = 1'b0;
    logic          int_enable = 1'b0;
    logic          parity_err = 1'b0;
    logic          nmi_en = 1'b0;
    logic [AW-1:0] aux_nmi = '0;
    logic          instr_end = 1'b0;
    logic [TW-1:0] ext_type = '0;
    logic          ack_start;
    logic [TW-1:0] ack_type;
    logic          nmi_pending;

    always #4 clk = ~clk;

    intr_recog #(.TYPE_W(TW), .AUX_W(AW), .NMI_TYPE(2)) u_intr_recog (
        .clk          (clk),
        .rst_n        (rst_n),
        .maskable_req (maskable_req),
        .int_enable   (int_enable),
        .parity_err   (parity_err),
        .nmi_en       (nmi_en),
        .aux_nmi      (aux_nmi),
        .instr_end    (instr_end),
        .ext_type     (ext_type),
        .ack_start    (ack_start),
        .ack_type     (ack_type),
        .nmi_pending  (nmi_pending)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";

    // reference model built from the requirements
    logic          m_primed = 1'b0;
    logic          m_prev = 1'b0;
    logic          m_pend = 1'b0;
    logic          m_ack = 1'b0;
    logic [TW-1:0] m_type = '0;

    task automatic compare();
        n_cmp++;
        if (ack_start !== m_ack || ack_type !== m_type || nmi_pending !== m_pend) begin
            n_bad++;
            $display("FAIL %s: got ack=%b type=%h pend=%b, expected ack=%b type=%h pend=%b",
                     tag, ack_start, ack_type, nmi_pending, m_ack, m_type, m_pend);
        end
    endtask

    task automatic step();
        logic          src;
        logic          rise;
        logic          n_ack;
        logic [TW-1:0] n_type;
        logic          n_pend;
        src    = (parity_err & nmi_en) | (|aux_nmi);
        rise   = m_primed & src & ~m_prev;
        n_ack  = instr_end & (m_pend | (maskable_req & int_enable));
        n_type = n_ack ? (m_pend ? 8'd2 : ext_type) : m_type;
        n_pend = rise | (m_pend & ~instr_end);
        @(posedge clk);
        #1;
        m_prev   = src;
        m_primed = 1'b1;
        m_ack    = n_ack;
        m_type   = n_type;
        m_pend   = n_pend;
        compare();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        m_primed = 1'b0;
        m_prev   = 1'b0;
        m_pend   = 1'b0;
        m_ack    = 1'b0;
        m_type   = '0;
        compare();
        rst_n = 1'b1;
    endtask

    task automatic quiet();
        maskable_req = 1'b0;
        int_enable   = 1'b0;
        parity_err   = 1'b0;
        nmi_en       = 1'b0;
        aux_nmi      = '0;
        instr_end    = 1'b0;
    endtask

    task automatic drain();
        quiet();
        step();
        instr_end = 1'b1;
        step();
        instr_end = 1'b0;
        step();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got no completion, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset values
        tag = "R1";
        quiet();
        do_reset();
        step();

        // R8: source high through reset release is not an edge
        tag = "R8";
        aux_nmi = 1'b1;
        do_reset();
        repeat (4) step();
        aux_nmi = 1'b0;
        step();
        aux_nmi = 1'b1;
        step();
        drain();

        // R4: every combination of parity, enable, auxiliary source
        tag = "R4";
        for (int c = 0; c < 8; c++) begin
            parity_err = c[2];
            nmi_en     = c[1];
            aux_nmi    = c[0];
            step();
            step();
            step();
            drain();
        end

        // R2, R3, R10: request / enable sweep over several type bytes
        for (int mr = 0; mr < 2; mr++) begin
            for (int en = 0; en < 2; en++) begin
                for (int k = 0; k < 8; k++) begin
                    logic [TW-1:0] t;
                    t = TW'(k * 37 + 1);
                    tag = (en == 1) ? "R2" : "R3";
                    maskable_req = mr[0];
                    int_enable   = en[0];
                    ext_type     = t;
                    step();
                    instr_end = 1'b1;
                    step();
                    instr_end = 1'b0;
                    tag = "R10";
                    ext_type = ~t;
                    step();
                    step();
                end
            end
        end
        quiet();
        step();

        // R5: NMI served with interrupts disabled
        tag = "R5";
        parity_err = 1'b1;
        nmi_en     = 1'b1;
        step();
        step();
        parity_err = 1'b0;
        step();
        instr_end = 1'b1;
        step();
        instr_end = 1'b0;
        step();

        // R6: several edges before service give one acknowledge
        tag = "R6";
        for (int i = 0; i < 3; i++) begin
            aux_nmi = 1'b1;
            step();
            aux_nmi = 1'b0;
            step();
        end
        instr_end = 1'b1;
        step();
        step();
        instr_end = 1'b0;
        step();

        // R7: NMI beats maskable at the same boundary
        tag = "R7";
        maskable_req = 1'b1;
        int_enable   = 1'b1;
        ext_type     = 8'h5A;
        aux_nmi      = 1'b1;
        step();
        aux_nmi   = 1'b0;
        instr_end = 1'b1;
        step();
        step();
        instr_end = 1'b0;
        step();
        quiet();
        step();

        // R9: edge in the servicing cycle re-arms the flag
        tag = "R9";
        aux_nmi = 1'b1;
        step();
        aux_nmi = 1'b0;
        step();
        aux_nmi   = 1'b1;
        instr_end = 1'b1;
        step();
        instr_end = 1'b0;
        step();
        instr_end = 1'b1;
        step();
        drain();

        finish_run();
    end

endmodule